// File: doc/BRIEF.md
# Watchdog Timer with Debug Pause

This block is a watchdog for a processor subsystem. A down-counter is loaded by software and loses two units on every tick from a programmable tick generator. If software does not reload the counter in time, the block raises a one-cycle reset request. Software can also raise that request at once by writing a force bit. A read-only cause register records whether the last request came from expiry or from a forced write. Eight scratch words hold data that software wants to keep across the reset that follows.

Counting pauses while the timer is disabled. It also pauses while any of three debug inputs is high and its mask bit is set: core 1 halted, core 0 halted, or a debug probe driving the bus. All three mask bits come out of reset set. Everything is reached through a 32-bit word bus with byte addresses, a write strobe and combinational read data.

Top module: `wdt_top`

## Requirements
- R1: After reset, control (0x00) reads 0x0700_0000, reason (0x08) reads 0, tick (0x2C) reads 0x0000_0600 and rst_req is low.
- R2: While control bit 30 is 0, the countdown value keeps its value whatever the tick generator does.
- R3: A write to control (0x00) with bit 31 set makes rst_req high for the next cycle and sets reason to 2 (bit 1). Bit 31 always reads back 0.
- R4: Control bits 26, 25 and 24 are masks for halt_cpu1, halt_cpu0 and probe_active. While an input is high and its mask bit is 1, the count holds. An input whose mask bit is 0 has no effect.
- R5: Control bits 23:0 read the countdown value. Each tick that finds the timer enabled and not paused lowers the count by 2.
- R6: A write to load (0x04) sets the countdown to the low 24 data bits in the next cycle. It takes priority over a decrement in the same cycle. Load always reads 0.
- R7: A qualifying tick that finds the count at 2 or below sets the count to 0, makes rst_req high for the next cycle and sets reason to 1 (bit 0). This repeats on every such tick while the count is at 0. A force in the same cycle takes precedence for the reason.
- R8: Reason (0x08) holds exactly one set bit after any request, bit 1 for forced and bit 0 for expiry. All other bits read 0.
- R9: The tick register holds the cycle count in bits 8:0 and the remaining count in bits 19:11. Writing the register reloads the remaining count. A tick occurs in each cycle where the remaining count is at most 1, and the remaining count then reloads. Otherwise it decrements, so the tick period is max(N,1) clocks.
- R10: Tick register bit 9 enables the generator and resets to 1. Bit 10 reads the same value. While the generator is disabled, the remaining count holds and no ticks occur.
- R11: Eight read/write scratch words sit at 0x0C through 0x28. Watchdog activity does not change them.
- R12: Reads from any other address, misaligned addresses included, return 0. Writes to those addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| halt_cpu1 | input | 1 | Core 1 is halted in debug |
| halt_cpu0 | input | 1 | Core 0 is halted in debug |
| probe_active | input | 1 | Debug probe is accessing the bus |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with a 10-bit counter and a 4-bit tick cycle field, and keeps the default eight scratch words and 6-bit address. The narrow tick field lets the bench try every cycle count from 0 to 15 and check the remaining count in every clock. The narrow counter lets the bench sweep load values at and around expiry quickly, which covers the 0, 1 and 2 boundaries and repeated expiry at zero. A per-cycle arithmetic model written from the requirements gives the expected value of every read and of rst_req.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Byte offsets of the register windows
   localparam int OFS_CTRL   = 'h00;
   localparam int OFS_LOAD   = 'h04;
   localparam int OFS_REASON = 'h08;
   localparam int OFS_SCR0   = 'h0C;

   // Control register fields
   localparam int CTL_FORCE_BIT = 31;
   localparam int CTL_EN_BIT    = 30;
   localparam int CTL_MASK_LSB  = 24;
   localparam int CTL_MASK_W    = 3;

   // Tick register fields
   localparam int TK_EN_BIT  = 9;
   localparam int TK_RUN_BIT = 10;
   localparam int TK_REM_LSB = 11;
   localparam int TK_MAX_W   = 9;

   localparam int CNT_MAX_W = 24;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'b00,
      CAUSE_TIMER = 2'b01,
      CAUSE_FORCE = 2'b10
   } cause_e;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int TICK_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [TICK_W-1:0] cfg_cycles,
   input  logic              cfg_en,
   output logic [TICK_W-1:0] cycles,
   output logic [TICK_W-1:0] remain,
   output logic              running,
   output logic              tick
);
   logic [TICK_W-1:0] cyc_q;
   logic [TICK_W-1:0] rem_q;
   logic              en_q;

   assign tick    = en_q && (rem_q <= TICK_W'(1));
   assign cycles  = cyc_q;
   assign remain  = rem_q;
   assign running = en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
         rem_q <= '0;
         en_q  <= 1'b1;
      end else if (cfg_we) begin
         cyc_q <= cfg_cycles;
         rem_q <= cfg_cycles;
         en_q  <= cfg_en;
      end else if (en_q) begin
         rem_q <= tick ? cyc_q : rem_q - TICK_W'(1);
      end
   end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int CNT_W = 24,
   parameter int STEP  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step_en,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_dec;
   logic             at_floor;

   assign at_floor = (cnt_q <= STEP_V);
   assign expire   = step_en && !load_en && at_floor;
   assign count    = cnt_q;

   generate
      if (STEP == 1) begin : g_unit
         assign cnt_dec = at_floor ? '0 : cnt_q - CNT_W'(1);
      end else begin : g_multi
         assign cnt_dec = at_floor ? '0 : cnt_q - STEP_V;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load_en) cnt_q <= load_val;
      else if (step_en) cnt_q <= cnt_dec;
   end
endmodule

// File: rtl/wdt_scratch.sv
module wdt_scratch #(
   parameter int N_WORDS = 8,
   parameter int ADDR_W  = 6,
   parameter int BASE    = 'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata
);
   logic [31:0] word_q [N_WORDS];
   logic [N_WORDS-1:0] sel;

   generate
      for (genvar i = 0; i < N_WORDS; i++) begin : g_word
         assign sel[i] = (addr == ADDR_W'(BASE + 4 * i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         word_q[i] <= '0;
            else if (we && sel[i]) word_q[i] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_WORDS; i++) begin
         if (sel[i]) rdata = word_q[i];
      end
   end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
   import wdt_pkg::*;
#(
   parameter int CNT_W     = 24,
   parameter int TICK_W    = 9,
   parameter int N_SCRATCH = 8,
   parameter int ADDR_W    = 6,
   parameter int STEP      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              halt_cpu1,
   input  logic              halt_cpu0,
   input  logic              probe_active,
   output logic              rst_req
);
   localparam int OFS_TICK = OFS_SCR0 + 4 * N_SCRATCH;

   generate
      if (CNT_W < 4 || CNT_W > CNT_MAX_W) begin : g_bad_cnt
         $error("wdt_top: CNT_W out of range");
      end
      if (TICK_W < 2 || TICK_W > TK_MAX_W) begin : g_bad_tick
         $error("wdt_top: TICK_W out of range");
      end
      if (N_SCRATCH < 1 || OFS_TICK >= (1 << ADDR_W)) begin : g_bad_map
         $error("wdt_top: register map does not fit ADDR_W");
      end
      if (STEP < 1 || STEP >= (1 << CNT_W)) begin : g_bad_step
         $error("wdt_top: STEP out of range");
      end
   endgenerate

   // Address decode
   logic hit_ctrl, hit_reason, hit_tick, hit_load;
   assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_load   = (bus_addr == ADDR_W'(OFS_LOAD));
   assign hit_reason = (bus_addr == ADDR_W'(OFS_REASON));
   assign hit_tick   = (bus_addr == ADDR_W'(OFS_TICK));

   logic wr_ctrl, wr_load, wr_tick, force_w;
   assign wr_ctrl = bus_we && hit_ctrl;
   assign wr_load = bus_we && hit_load;
   assign wr_tick = bus_we && hit_tick;
   assign force_w = wr_ctrl && bus_wdata[CTL_FORCE_BIT];

   // Control state
   logic                  ctl_en_q;
   logic [CTL_MASK_W-1:0] ctl_mask_q;
   cause_e                cause_q;
   logic                  req_q;

   // Tick generator
   logic [TICK_W-1:0] tk_cycles, tk_remain;
   logic              tk_running, tick_pulse;

   wdt_tick_gen #(.TICK_W(TICK_W)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (wr_tick),
      .cfg_cycles (bus_wdata[TICK_W-1:0]),
      .cfg_en     (bus_wdata[TK_EN_BIT]),
      .cycles     (tk_cycles),
      .remain     (tk_remain),
      .running    (tk_running),
      .tick       (tick_pulse)
   );

   // Pause and countdown
   logic paused, step_en, expire;
   logic [CNT_W-1:0] cnt_val;

   assign paused  = |(ctl_mask_q & {halt_cpu1, halt_cpu0, probe_active});
   assign step_en = tick_pulse && ctl_en_q && !paused;

   wdt_countdown #(.CNT_W(CNT_W), .STEP(STEP)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (wr_load),
      .load_val (bus_wdata[CNT_W-1:0]),
      .step_en  (step_en),
      .count    (cnt_val),
      .expire   (expire)
   );

   // Scratch words
   logic [31:0] scr_rdata;

   wdt_scratch #(.N_WORDS(N_SCRATCH), .ADDR_W(ADDR_W), .BASE(OFS_SCR0)) u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .we    (bus_we),
      .wdata (bus_wdata),
      .rdata (scr_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en_q   <= 1'b0;
         ctl_mask_q <= '1;
         cause_q    <= CAUSE_NONE;
         req_q      <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctl_en_q   <= bus_wdata[CTL_EN_BIT];
            ctl_mask_q <= bus_wdata[CTL_MASK_LSB +: CTL_MASK_W];
         end
         req_q <= force_w || expire;
         if (force_w)     cause_q <= CAUSE_FORCE;
         else if (expire) cause_q <= CAUSE_TIMER;
      end
   end

   assign rst_req = req_q;

   // Read mux
   always_comb begin
      bus_rdata = scr_rdata;
      if (hit_ctrl) begin
         bus_rdata = '0;
         bus_rdata[CTL_EN_BIT] = ctl_en_q;
         bus_rdata[CTL_MASK_LSB +: CTL_MASK_W] = ctl_mask_q;
         bus_rdata[CNT_W-1:0] = cnt_val;
      end else if (hit_reason) begin
         bus_rdata = '0;
         bus_rdata[1:0] = cause_q;
      end else if (hit_tick) begin
         bus_rdata = '0;
         bus_rdata[TICK_W-1:0] = tk_cycles;
         bus_rdata[TK_EN_BIT]  = tk_running;
         bus_rdata[TK_RUN_BIT] = tk_running;
         bus_rdata[TK_REM_LSB +: TICK_W] = tk_remain;
      end
   end
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks #(
   parameter int CNT_W  = 24,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              force_bit,
   input logic [CNT_W-1:0]  load_bits,
   input logic              halt_cpu1,
   input logic              halt_cpu0,
   input logic              probe_active,
   input logic              rst_req,
   input logic [CNT_W-1:0]  count,
   input logic              ctl_en,
   input logic [2:0]        ctl_mask,
   input logic [1:0]        cause,
   input logic              tick,
   input logic              tick_run
);
   logic load_w, force_w, pause_w;
   assign load_w  = bus_we && (bus_addr == ADDR_W'(4));
   assign force_w = bus_we && (bus_addr == ADDR_W'(0)) && force_bit;
   assign pause_w = |(ctl_mask & {halt_cpu1, halt_cpu0, probe_active});

   // R3: a force write yields a request and the force cause next cycle
   assert_force_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      force_w |=> (rst_req && cause == 2'b10));

   // R2: disabled timer keeps its count
   assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_en && !load_w) |=> $stable(count));

   // R4: an unmasked debug input freezes the count
   assert_pause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_w && !load_w) |=> $stable(count));

   // R5: without a load the count never rises
   assert_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_w |=> (count <= $past(count)));

   // R6: a load sets the count to the written value
   assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_w |=> (count == $past(load_bits)));

   // R8: a request always comes with exactly one cause bit
   assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($countones(cause) == 1));

   // R10: no ticks while the generator is stopped
   assert_no_tick_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_run |-> !tick);
endmodule

bind wdt_top wdt_checks #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_wdt_checks (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_we       (bus_we),
   .force_bit    (bus_wdata[31]),
   .load_bits    (bus_wdata[CNT_W-1:0]),
   .halt_cpu1    (halt_cpu1),
   .halt_cpu0    (halt_cpu0),
   .probe_active (probe_active),
   .rst_req      (rst_req),
   .count        (cnt_val),
   .ctl_en       (ctl_en_q),
   .ctl_mask     (ctl_mask_q),
   .cause        (cause_q),
   .tick         (tick_pulse),
   .tick_run     (tk_running)
);

// File: tb/wdt_top_bench.sv
module wdt_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 10;
   localparam int TW = 4;
   localparam int AW = 6;
   localparam int WD_LIMIT = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          h1 = 1'b0, h0 = 1'b0, pj = 1'b0;
   logic          rst_req;

   wdt_top #(.CNT_W(CW), .TICK_W(TW), .N_SCRATCH(8), .ADDR_W(AW), .STEP(2)) u_wdt_top (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_we       (bus_we),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .halt_cpu1    (h1),
      .halt_cpu0    (h0),
      .probe_active (pj),
      .rst_req      (rst_req)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   // Reference state, written from the requirements
   int unsigned m_cnt = 0;
   bit          m_en = 0;
   bit [2:0]    m_mask = 3'b111;
   bit [1:0]    m_rsn = 0;
   bit          m_req = 0;
   int unsigned m_tcyc = 0, m_trem = 0;
   bit          m_ten = 1;
   logic [31:0] m_scr [8];

   function automatic bit is_scr(logic [AW-1:0] a);
      return (a >= 6'h0C) && (a <= 6'h28) && (a[1:0] == 2'b00);
   endfunction

   function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
      logic [31:0] r = '0;
      if (a == 6'h00) begin
         r[30] = m_en; r[26:24] = m_mask; r[CW-1:0] = m_cnt[CW-1:0];
      end else if (a == 6'h08) begin
         r[1:0] = m_rsn;
      end else if (is_scr(a)) begin
         r = m_scr[(a - 6'h0C) >> 2];
      end else if (a == 6'h2C) begin
         r[TW-1:0] = m_tcyc[TW-1:0]; r[9] = m_ten; r[10] = m_ten;
         r[11 +: TW] = m_trem[TW-1:0];
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // One clock: drive at negedge, advance the model, compare at next negedge
   task automatic step(input bit we, input logic [AW-1:0] a, input logic [31:0] d, input string tag);
      bit tk, ps, frc, ld, dec, ex;
      int unsigned ncnt;
      bus_we = we; bus_addr = a; bus_wdata = d;
      tk  = m_ten && (m_trem <= 1);
      ps  = |(m_mask & {h1, h0, pj});
      frc = we && (a == 6'h00) && d[31];
      ld  = we && (a == 6'h04);
      dec = tk && m_en && !ps;
      ex  = dec && !ld && (m_cnt <= 2);
      ncnt = ld ? int'(d[CW-1:0]) : (dec ? ((m_cnt <= 2) ? 0 : m_cnt - 2) : m_cnt);
      m_req = frc || ex;
      if (frc)     m_rsn = 2'b10;
      else if (ex) m_rsn = 2'b01;
      if (we && a == 6'h2C) begin
         m_tcyc = d[TW-1:0]; m_trem = d[TW-1:0]; m_ten = d[9];
      end else if (m_ten) begin
         m_trem = tk ? m_tcyc : m_trem - 1;
      end
      if (we && a == 6'h00) begin
         m_en = d[30]; m_mask = d[26:24];
      end
      if (we && is_scr(a)) m_scr[(a - 6'h0C) >> 2] = d;
      m_cnt = ncnt;
      @(posedge clk);
      @(negedge clk);
      check(frc ? "R3 rst_req" : "R7 rst_req", {31'b0, rst_req}, {31'b0, m_req});
      if (!we) check(tag, bus_rdata, exp_rd(a));
      bus_we = 1'b0;
   endtask

   task automatic idle(input int n, input logic [AW-1:0] a, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, a, 32'h0, tag);
   endtask

   initial begin
      while (cycles < WD_LIMIT) begin
         @(posedge clk);
         cycles++;
      end
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) m_scr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      check("R1 rst_req", {31'b0, rst_req}, 32'h0);
      bus_addr = 6'h00; #1 check("R1 ctrl", bus_rdata, 32'h0700_0000);
      bus_addr = 6'h08; #1 check("R1 reason", bus_rdata, 32'h0);
      bus_addr = 6'h2C; #1 check("R1 tick", bus_rdata, 32'h0000_0600);
      // R12: unused and misaligned addresses read 0
      for (int a = 6'h30; a <= 6'h3C; a += 4) step(1'b0, AW'(a), 32'h0, "R12 unused");
      step(1'b0, 6'h01, 32'h0, "R12 misaligned");
      step(1'b1, 6'h31, 32'hFFFF_FFFF, "R12 write");
      step(1'b0, 6'h31, 32'h0, "R12 misaligned");
      step(1'b0, 6'h0D, 32'h0, "R12 misaligned");
      // R11: scratch words
      for (int i = 0; i < 8; i++)
         step(1'b1, AW'(6'h0C + 4 * i), 32'hA5C3_0000 ^ (32'h1357_9BDF * (i + 1)), "R11");
      for (int i = 0; i < 8; i++) step(1'b0, AW'(6'h0C + 4 * i), 32'h0, "R11 scratch");
      // R9: every tick cycle count, remaining count traced each clock
      for (int n = 0; n < 16; n++) begin
         step(1'b1, 6'h2C, 32'h200 | n, "R9");
         idle(20, 6'h2C, "R9 tick");
      end
      // R10: stopped generator holds and gives no ticks
      step(1'b1, 6'h2C, 32'h005, "R10");
      idle(6, 6'h2C, "R10 tick");
      step(1'b1, 6'h04, 32'd30, "R6");
      step(1'b1, 6'h00, 32'h4000_0000, "R10");
      idle(8, 6'h00, "R10 count held");
      // R5/R7: countdown to expiry with period 3
      step(1'b1, 6'h2C, 32'h203, "R9");
      step(1'b1, 6'h04, 32'd40, "R6");
      step(1'b0, 6'h04, 32'h0, "R6 load reads 0");
      step(1'b1, 6'h00, 32'h4700_0000, "R5");
      idle(80, 6'h00, "R5 count");
      step(1'b0, 6'h08, 32'h0, "R8 reason timer");
      // R4: each debug input with its mask, then masks cleared
      step(1'b1, 6'h2C, 32'h202, "R9");
      step(1'b1, 6'h04, 32'd100, "R6");
      h1 = 1'b1; idle(10, 6'h00, "R4 core1");
      h1 = 1'b0; h0 = 1'b1; idle(10, 6'h00, "R4 core0");
      h0 = 1'b0; pj = 1'b1; idle(10, 6'h00, "R4 probe");
      step(1'b1, 6'h00, 32'h4000_0000, "R4");
      h1 = 1'b1; h0 = 1'b1; idle(10, 6'h00, "R4 masked off");
      h1 = 1'b0; h0 = 1'b0; pj = 1'b0;
      // R3: forced request, then R2: disabled hold
      step(1'b1, 6'h00, 32'hC700_0000, "R3");
      step(1'b0, 6'h08, 32'h0, "R3 reason force");
      step(1'b0, 6'h00, 32'h0, "R3 force reads 0");
      step(1'b1, 6'h00, 32'h0000_0000, "R2");
      step(1'b1, 6'h04, 32'd50, "R6");
      idle(20, 6'h00, "R2 hold");
      // R7: expiry boundaries with a tick every clock
      step(1'b1, 6'h2C, 32'h200, "R9");
      step(1'b1, 6'h00, 32'h4000_0000, "R7");
      for (int l = 0; l < 7; l++) begin
         step(1'b1, 6'h04, 32'(l), "R6");
         idle(5, 6'h00, "R7 expiry");
         step(1'b0, 6'h08, 32'h0, "R8 reason");
      end
      // R7: force and expiry together, force reason wins
      step(1'b1, 6'h04, 32'd2, "R6");
      step(1'b1, 6'h00, 32'hC000_0000, "R7");
      step(1'b0, 6'h08, 32'h0, "R7 force priority");
      // R11: scratch unchanged after all watchdog activity
      for (int i = 0; i < 8; i++) step(1'b0, AW'(6'h0C + 4 * i), 32'h0, "R11 scratch kept");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule